// File: doc/BRIEF.md
# Reference Selector and Loop Mode Sequencer

This block decides which of several monitored clock inputs drives one digital PLL, and it steps the loop through its operating modes. Each input arrives with a validity flag from an upstream monitor and a programmable priority. The block has an automatic mode and a forced mode. In the automatic mode it picks the best valid input under either a revertive or a nonrevertive policy. In the forced mode it takes the input named by a manual index.

Each time the loop moves to a new reference, the block raises a one-cycle request so that the loop can absorb the phase step. The loop's lock indication moves the mode between acquiring and locked, and the block reports which bandwidth setting applies. While the loop is locked, a history averager tracks the loop's instantaneous frequency word. If the reference is lost, the loop falls back to that averaged word for holdover. It falls back to free-run instead when the history is too short.

Top module: `ref_sel_ctrl`

## Requirements
- R1: While rst_ni is low, sel_valid_o, pbo_req_o, hold_freq_o and wide_bw_o are 0 and mode_o is 0. The mode codes are free-run=0, acquiring=1, locked=2 and holdover=3.
- R2: In automatic mode (manual_en_i=0), when a new reference is chosen, it is the valid input with the smallest 3-bit priority value. Input i's priority is prio_i[3i+2:3i]. Ties go to the lowest index. sel_o and sel_valid_o change one clock after the inputs change.
- R3: With manual_en_i=1, the block takes manual_sel_i as the reference when that input is valid. When it is not valid, the block drops the reference (sel_valid_o=0).
- R4: With revertive_i=0, the current reference is kept for as long as it stays valid, even if an input with a better priority becomes valid.
- R5: With revertive_i=1, the block moves to a valid input whose priority value is strictly smaller than the current one.
- R6: When the selected input becomes invalid, the next clock moves to the best valid input. If no input is valid, sel_valid_o drops instead.
- R7: pbo_req_o is high for one cycle, in the same cycle that a reference is taken. This happens when the new reference differs from the previous one or when there was no reference before.
- R8: With a reference, free-run or holdover goes to acquiring. Acquiring goes to locked when lock_i=1, and locked goes back to acquiring when lock_i=0. A reference switch alone does not leave locked.
- R9: When no reference remains, the mode becomes holdover if the history is full, and free-run otherwise. Holdover persists until a reference returns. The history is full once the locked-mode tick count reaches 2^S.
- R10: Every 4th clock, while the mode is locked, the averager takes one sample. The first sample loads freq_i. Each later sample adds (freq_i - avg)/2^S, with the division rounded towards minus infinity. The average has 6 fraction bits, and S is 2, 4 or 6 for win_sel_i 0, 1 or 2/3. hold_freq_o is the integer part, and it does not change outside locked mode.
- R11: wide_bw_o is high exactly when mode_o is acquiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 4 | Per-input validity flags |
| prio_i | input | 12 | Packed 3-bit priorities; a lower value is a better priority |
| manual_en_i | input | 1 | Forced selection enable |
| manual_sel_i | input | 2 | Forced input index |
| revertive_i | input | 1 | Revertive policy enable |
| lock_i | input | 1 | Lock indication from the loop |
| freq_i | input | 16 | Instantaneous frequency word of the loop |
| win_sel_i | input | 2 | Averaging window select |
| sel_o | output | 2 | Selected input index |
| sel_valid_o | output | 1 | A reference is in use |
| mode_o | output | 2 | Loop mode |
| pbo_req_o | output | 1 | Phase build-out request pulse |
| hold_freq_o | output | 16 | Averaged holdover frequency word |
| wide_bw_o | output | 1 | Acquisition bandwidth applies |

## Verification
The selection is exercised with several input patterns:
- A better-priority input appears while the policy is nonrevertive, which shows that R4 and R5 are distinct.
- The current reference fails while a fallback exists, and then while no input is valid, which shows a switch apart from a drop.
- A forced index points at a valid input, and then at an invalid one.
- The reference is lost twice: once with a short averaging window that is already full, and once with a long window that is not yet full. This shows holdover apart from the free-run fallback.
- A behavioural model tracks the averaged word through a varying frequency sequence, which catches rounding and seeding errors.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_LOCK = 2'd2,
    MODE_HOLD = 2'd3
  } mode_e;
endpackage

// File: rtl/ref_pick.sv
module ref_pick #(
  parameter int N_IN  = 4,
  parameter int PRI_W = 3,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]       valid_i,
  input  logic [N_IN*PRI_W-1:0] prio_i,
  output logic [IDX_W-1:0]      best_o,
  output logic                  any_o
);
  logic [PRI_W-1:0] best_pri;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best_o   = '0;
    any_o    = 1'b0;
    best_pri = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (valid_i[i] && (!any_o || prio_i[i*PRI_W +: PRI_W] < best_pri)) begin
        any_o    = 1'b1;
        best_o   = IDX_W'(i);
        best_pri = prio_i[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/sel_fsm.sv
module sel_fsm
  import refsel_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int PRI_W = 3,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IN-1:0]       valid_i,
  input  logic [N_IN*PRI_W-1:0] prio_i,
  input  logic [IDX_W-1:0]      best_i,
  input  logic                  any_i,
  input  logic                  manual_en_i,
  input  logic [IDX_W-1:0]      manual_sel_i,
  input  logic                  revertive_i,
  input  logic                  lock_i,
  input  logic                  hist_full_i,
  output logic [IDX_W-1:0]      sel_o,
  output logic                  have_o,
  output logic                  pbo_o,
  output mode_e                 mode_o
);
  logic [IDX_W-1:0] sel_q, sel_n;
  logic             have_q, have_n, pbo_q, cur_ok, man_ok, better;
  mode_e            mode_q, mode_n;

  assign cur_ok = have_q && valid_i[sel_q];
  assign man_ok = (32'(manual_sel_i) < N_IN) && valid_i[manual_sel_i];
  assign better = any_i &&
                  (prio_i[best_i*PRI_W +: PRI_W] < prio_i[sel_q*PRI_W +: PRI_W]);

  always_comb begin
    if (manual_en_i) begin
      have_n = man_ok;
      sel_n  = man_ok ? manual_sel_i : sel_q;
    end else if (cur_ok) begin
      have_n = 1'b1;
      sel_n  = (revertive_i && better) ? best_i : sel_q;
    end else begin
      have_n = any_i;
      sel_n  = any_i ? best_i : sel_q;
    end
  end

  always_comb begin
    mode_n = mode_q;
    if (have_n) begin
      unique case (mode_q)
        MODE_FREE, MODE_HOLD: mode_n = MODE_ACQ;
        MODE_ACQ:             mode_n = lock_i ? MODE_LOCK : MODE_ACQ;
        MODE_LOCK:            mode_n = lock_i ? MODE_LOCK : MODE_ACQ;
        default:              mode_n = MODE_FREE;
      endcase
    end else if (mode_q != MODE_HOLD) begin
      mode_n = hist_full_i ? MODE_HOLD : MODE_FREE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      have_q <= 1'b0;
      pbo_q  <= 1'b0;
      mode_q <= MODE_FREE;
    end else begin
      sel_q  <= sel_n;
      have_q <= have_n;
      pbo_q  <= have_n && (!have_q || sel_n != sel_q);
      mode_q <= mode_n;
    end
  end

  assign sel_o  = sel_q;
  assign have_o = have_q;
  assign pbo_o  = pbo_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/hist_avg.sv
module hist_avg #(
  parameter int FREQ_W   = 16,
  parameter int TICK_DIV = 4,
  parameter int SH0      = 2,
  parameter int SH1      = 4,
  parameter int SH2      = 6,
  localparam int FRAC    = SH2,
  localparam int AW      = FREQ_W + FRAC,
  localparam int DW      = AW + 2,
  localparam int CNT_W   = FRAC + 1,
  localparam int DIV_W   = $clog2(TICK_DIV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [1:0]        win_sel_i,
  output logic [FREQ_W-1:0] avg_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(1) << FRAC;

  logic [AW-1:0]        acc_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [DIV_W-1:0]     div_q;
  logic [7:0]           sh;
  logic                 tick;
  logic signed [DW-1:0] diff, step;

  always_comb begin
    unique case (win_sel_i)
      2'd0:    sh = 8'(SH0);
      2'd1:    sh = 8'(SH1);
      default: sh = 8'(SH2);
    endcase
  end

  assign tick   = (div_q == DIV_W'(TICK_DIV - 1));
  assign diff   = $signed({2'b00, freq_i, {FRAC{1'b0}}}) - $signed({2'b00, acc_q});
  assign step   = diff >>> sh;
  assign full_o = (cnt_q >= (CNT_W'(1) << sh));
  assign avg_o  = acc_q[AW-1:FRAC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick && lock_i) begin
        // first sample seeds the average
        acc_q <= (cnt_q == '0) ? {freq_i, {FRAC{1'b0}}} : acc_q + step[AW-1:0];
        if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl
  import refsel_pkg::*;
#(
  parameter int N_IN     = 4,
  parameter int PRI_W    = 3,
  parameter int FREQ_W   = 16,
  parameter int TICK_DIV = 4,
  parameter int SH0      = 2,
  parameter int SH1      = 4,
  parameter int SH2      = 6,
  localparam int IDX_W   = $clog2(N_IN)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IN-1:0]       valid_i,
  input  logic [N_IN*PRI_W-1:0] prio_i,
  input  logic                  manual_en_i,
  input  logic [IDX_W-1:0]      manual_sel_i,
  input  logic                  revertive_i,
  input  logic                  lock_i,
  input  logic [FREQ_W-1:0]     freq_i,
  input  logic [1:0]            win_sel_i,
  output logic [IDX_W-1:0]      sel_o,
  output logic                  sel_valid_o,
  output logic [1:0]            mode_o,
  output logic                  pbo_req_o,
  output logic [FREQ_W-1:0]     hold_freq_o,
  output logic                  wide_bw_o
);
  logic [IDX_W-1:0] best;
  logic             any_valid, hist_full;
  mode_e            mode;

  ref_pick #(.N_IN(N_IN), .PRI_W(PRI_W)) u_pick (
    .valid_i(valid_i), .prio_i(prio_i), .best_o(best), .any_o(any_valid)
  );

  sel_fsm #(.N_IN(N_IN), .PRI_W(PRI_W)) u_fsm (
    .clk_i, .rst_ni, .valid_i, .prio_i,
    .best_i(best), .any_i(any_valid),
    .manual_en_i, .manual_sel_i, .revertive_i, .lock_i,
    .hist_full_i(hist_full),
    .sel_o(sel_o), .have_o(sel_valid_o), .pbo_o(pbo_req_o), .mode_o(mode)
  );

  hist_avg #(.FREQ_W(FREQ_W), .TICK_DIV(TICK_DIV), .SH0(SH0), .SH1(SH1), .SH2(SH2)) u_avg (
    .clk_i, .rst_ni, .lock_i(mode == MODE_LOCK), .freq_i, .win_sel_i,
    .avg_o(hold_freq_o), .full_o(hist_full)
  );

  assign mode_o    = mode;
  assign wide_bw_o = (mode == MODE_ACQ);
endmodule

// File: rtl/ref_sel_ctrl_chk.sv
module ref_sel_ctrl_chk #(
  parameter int N_IN   = 4,
  parameter int FREQ_W = 16,
  localparam int IDX_W = $clog2(N_IN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IN-1:0]   valid_i,
  input logic              manual_en_i,
  input logic [IDX_W-1:0]  manual_sel_i,
  input logic [IDX_W-1:0]  sel_o,
  input logic              sel_valid_o,
  input logic [1:0]        mode_o,
  input logic              pbo_req_o,
  input logic [FREQ_W-1:0] hold_freq_o
);
  logic [N_IN-1:0]  valid_q;
  logic             man_en_q;
  logic [IDX_W-1:0] man_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= '0;
      man_en_q  <= 1'b0;
      man_sel_q <= '0;
    end else begin
      valid_q   <= valid_i;
      man_en_q  <= manual_en_i;
      man_sel_q <= manual_sel_i;
    end
  end

  AST_SEL_WAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> valid_q[sel_o]); // R2

  AST_MANUAL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && man_en_q) |-> (sel_o == man_sel_q)); // R3

  AST_PBO_ON_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && (!$past(sel_valid_o) || sel_o != $past(sel_o))) |-> pbo_req_o); // R7

  AST_REF_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (mode_o == 2'd1 || mode_o == 2'd2)); // R8

  AST_NOREF_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_o |-> (mode_o == 2'd0 || mode_o == 2'd3)); // R9

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && $past(mode_o) == 2'd3) |-> $stable(hold_freq_o)); // R10
endmodule

bind ref_sel_ctrl ref_sel_ctrl_chk #(.N_IN(N_IN), .FREQ_W(FREQ_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .manual_en_i(manual_en_i), .manual_sel_i(manual_sel_i),
  .sel_o(sel_o), .sel_valid_o(sel_valid_o), .mode_o(mode_o),
  .pbo_req_o(pbo_req_o), .hold_freq_o(hold_freq_o)
);

// File: tb/ref_sel_ctrl_tb_top.sv
`timescale 1ns/1ps
module ref_sel_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  valid_i = '0;
  logic [11:0] prio_i = '0;
  logic        manual_en_i = 1'b0;
  logic [1:0]  manual_sel_i = '0;
  logic        revertive_i = 1'b0;
  logic        lock_i = 1'b0;
  logic [15:0] freq_i = '0;
  logic [1:0]  win_sel_i = '0;
  logic [1:0]  sel_o;
  logic        sel_valid_o;
  logic [1:0]  mode_o;
  logic        pbo_req_o;
  logic [15:0] hold_freq_o;
  logic        wide_bw_o;

  int errors = 0;
  int checks = 0;

  always #10 clk_i = ~clk_i;

  ref_sel_ctrl dut_i (
    .clk_i, .rst_ni, .valid_i, .prio_i, .manual_en_i, .manual_sel_i,
    .revertive_i, .lock_i, .freq_i, .win_sel_i,
    .sel_o, .sel_valid_o, .mode_o, .pbo_req_o, .hold_freq_o, .wide_bw_o
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pr(input int i);
    return int'(prio_i[i*3 +: 3]);
  endfunction

  // behavioural reference model
  int m_sel, m_have, m_pbo, m_mode, m_div, m_cnt;
  longint m_acc;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sel = 0; m_have = 0; m_pbo = 0; m_mode = 0; m_div = 0; m_cnt = 0; m_acc = 0;
    end else begin
      int best, hn, sn, sh, full, mn;
      best = -1;
      for (int i = 0; i < 4; i++)
        if (valid_i[i] && (best < 0 || pr(i) < pr(best))) best = i;
      if (manual_en_i) begin
        hn = valid_i[manual_sel_i] ? 1 : 0;
        sn = (hn != 0) ? int'(manual_sel_i) : m_sel;
      end else if (m_have != 0 && valid_i[m_sel]) begin
        hn = 1;
        sn = (revertive_i && pr(best) < pr(m_sel)) ? best : m_sel;
      end else begin
        hn = (best >= 0) ? 1 : 0;
        sn = (hn != 0) ? best : m_sel;
      end
      sh = (win_sel_i == 0) ? 2 : (win_sel_i == 1) ? 4 : 6;
      full = (m_cnt >= (1 << sh)) ? 1 : 0;
      mn = m_mode;
      if (hn != 0) begin
        if (m_mode == 0 || m_mode == 3) mn = 1;
        else mn = lock_i ? 2 : 1;
      end else if (m_mode != 3) begin
        mn = (full != 0) ? 3 : 0;
      end
      if (m_div == 3 && m_mode == 2) begin
        longint tgt;
        tgt = longint'(freq_i) <<< 6;
        if (m_cnt == 0) m_acc = tgt;
        else m_acc = m_acc + ((tgt - m_acc) >>> sh);
        if (m_cnt < 64) m_cnt++;
      end
      m_div = (m_div + 1) % 4;
      m_pbo = (hn != 0 && (m_have == 0 || sn != m_sel)) ? 1 : 0;
      m_sel = sn; m_have = hn; m_mode = mn;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (m_have != 0) chk("R2 sel_o vs model", sel_o, m_sel);
      chk("R6 sel_valid_o vs model", sel_valid_o, m_have);
      chk("R7 pbo_req_o vs model", pbo_req_o, m_pbo);
      chk("R8 mode_o vs model", mode_o, m_mode);
      chk("R10 hold_freq_o vs model", hold_freq_o, m_acc >>> 6);
      chk("R11 wide_bw_o vs model", wide_bw_o, (m_mode == 1) ? 1 : 0);
    end
  end

  task automatic step_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      freq_i = 16'(1000 + ((k * 37 + 11) % 200));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    prio_i = {3'd0, 3'd2, 3'd1, 3'd3}; // in3=0 in2=2 in1=1 in0=3
    freq_i = 16'd1000;
    repeat (3) @(negedge clk_i);
    chk("R1 sel_valid_o reset", sel_valid_o, 0);
    chk("R1 mode_o reset", mode_o, 0);
    chk("R1 pbo_req_o reset", pbo_req_o, 0);
    chk("R1 hold_freq_o reset", hold_freq_o, 0);
    chk("R1 wide_bw_o reset", wide_bw_o, 0);
    rst_ni = 1'b1;

    @(negedge clk_i); valid_i = 4'b0101;
    @(negedge clk_i);
    chk("R2 best of in0/in2", sel_o, 2);
    chk("R2 sel_valid_o", sel_valid_o, 1);
    chk("R7 pbo on first ref", pbo_req_o, 1);
    chk("R8 free-run to acquiring", mode_o, 1);
    chk("R11 wide bw in acquiring", wide_bw_o, 1);
    lock_i = 1'b1;
    @(negedge clk_i);
    chk("R7 pbo single cycle", pbo_req_o, 0);
    @(negedge clk_i);
    chk("R8 acquiring to locked", mode_o, 2);
    chk("R11 narrow bw in locked", wide_bw_o, 0);
    step_n(30);

    valid_i = 4'b1101;
    step_n(2);
    chk("R4 nonrevertive keeps in2", sel_o, 2);
    revertive_i = 1'b1;
    @(negedge clk_i);
    chk("R5 revertive moves to in3", sel_o, 3);
    chk("R7 pbo on revert", pbo_req_o, 1);
    chk("R8 switch stays locked", mode_o, 2);

    valid_i = 4'b0101;
    @(negedge clk_i);
    chk("R6 failover to in2", sel_o, 2);
    chk("R6 still has ref", sel_valid_o, 1);
    step_n(4);

    valid_i = 4'b0000;
    @(negedge clk_i);
    chk("R6 no ref left", sel_valid_o, 0);
    chk("R9 holdover with full history", mode_o, 3);
    held = hold_freq_o;
    step_n(10);
    chk("R10 holdover word frozen", hold_freq_o, held);
    chk("R9 holdover persists", mode_o, 3);
    lock_i = 1'b0;

    manual_en_i = 1'b1; manual_sel_i = 2'd0; valid_i = 4'b1111;
    @(negedge clk_i);
    chk("R3 forced in0", sel_o, 0);
    chk("R8 holdover to acquiring", mode_o, 1);
    step_n(3);
    manual_sel_i = 2'd1; valid_i = 4'b1101;
    @(negedge clk_i);
    chk("R3 forced invalid drops ref", sel_valid_o, 0);
    step_n(3);

    manual_en_i = 1'b0; revertive_i = 1'b0; win_sel_i = 2'd3;
    valid_i = 4'b0101;
    step_n(2);
    lock_i = 1'b1;
    step_n(8);
    valid_i = 4'b0000;
    @(negedge clk_i);
    chk("R9 free-run when long window not full", mode_o, 0);
    step_n(6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule